// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port inside a chip and an external static RAM that has no clock of its own. A client offers one access at a time with a valid/ready handshake: a direction flag, an 18-bit word address and, for writes, a 4-bit data nibble. Reads come back as a nibble with a single-cycle valid strobe. On the memory side the controller owns the address bus, the three active-low strobes (chip select, write strobe, output enable) and a split 4-bit data bus: outgoing data, a drive enable, and incoming data.

Every timing rule of the memory is a nanosecond parameter. The controller turns each one into a count of whole system clock cycles, rounding up, so a different clock or a slower memory needs only new parameter values. After reset it waits out a long supply-settling interval before it accepts any access. It times the output-enable window for reads and the write-strobe window for writes. When a write follows a read, it adds a bus-turnaround gap so that it never drives the data pins while the memory may still be driving them. All strobes come straight from flip-flops, so the memory never sees a decode glitch.

Top module: `asram_ctrl`

## Requirements
- R1: From reset, and for HOLD = ceil(T_PWRUP_NS / CLK_PERIOD_NS) rising edges after reset is released, memCeN, memWeN and memOeN stay 1 and reqReady stays 0. reqReady is 1 after exactly HOLD edges.
- R2: A read delivers the memory nibble at the requested address on rdData. rdValid is 1 for exactly one cycle per read.
- R3: A read holds memCeN=0, memOeN=0 and memWeN=1 for exactly RD = ceil(T_AA_NS / CLK_PERIOD_NS) cycles, starting the cycle after acceptance. rdValid is seen in the cycle after that window.
- R4: A write holds memCeN=0, memWeN=0, memOeN=1 and dataOe=1 for exactly WR = ceil(max(T_PWE_NS, T_SD_NS, T_AW_NS, T_SCE_NS) / CLK_PERIOD_NS) cycles. memAddr and memDout equal the requested address and data, unchanged, for the whole window.
- R5: A nibble written to an address is returned by a later read of that address. Every bit of the 18-bit address reaches memAddr.
- R6: dataOe is 1 only while memWeN=0 and memOeN=1. The controller never drives the bus while the memory output is enabled.
- R7: A write that directly follows a read spends TURN = ceil(T_HZOE_NS / CLK_PERIOD_NS) cycles with all three strobes at 1 before memWeN falls. A write that follows a write, or the hold-off, lowers memWeN in the first cycle after acceptance.
- R8: reqReady is 1 only when the controller is idle. A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until the access ends.
- R9: After each access the strobes return to 1 for at least one cycle, leaving the memory in standby, before the next access begins.
- R10: A synchronous reset during an access raises all strobes and lowers reqReady in the next cycle. The full hold-off then runs again before the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (18) | Word address |
| reqWdata | input | DATA_W (4) | Write nibble |
| rdValid | output | 1 | One-cycle strobe: rdData holds read result |
| rdData | output | DATA_W (4) | Read nibble |
| memAddr | output | ADDR_W (18) | Memory address bus |
| memCeN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memDout | output | DATA_W (4) | Data toward memory |
| dataOe | output | 1 | Drive enable for memDout onto the pins |
| memDin | input | DATA_W (4) | Data from memory pins |

## Verification
Two functions can meet in the same cycle: the end of a read, where the memory may still be driving the pins, and the start of a write that wants to drive them. The stimulus table puts writes directly behind reads. The bench counts the all-high cycles before the write strobe falls and compares that count with the turnaround count (R7). A monitor flags any cycle where the drive enable and the memory output enable are active together (R6). Write-after-write pairs in the same table show that the gap is not inserted where it is not needed.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch address and write data
    logic captureRd;  // sample memory pins into read register
  } dpStrobe_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int PWR_CYC  = 10000,
  parameter int RD_CYC   = 1,
  parameter int WR_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 14
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output dpStrobe_t strobe,
  output logic      memCeN,
  output logic      memWeN,
  output logic      memOeN,
  output logic      dataOe
);

  ctrlState_t state, nextState;
  logic [CNT_W-1:0] waitCnt, nextCnt;
  logic lastRead, nextLastRead;

  always_comb begin
    nextState    = state;
    nextCnt      = waitCnt;
    nextLastRead = lastRead;
    case (state)
      ST_PWRUP: begin
        if (waitCnt == '0) nextState = ST_IDLE;
        else               nextCnt   = waitCnt - 1'b1;
      end
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            nextState = ST_READ;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end else if (lastRead) begin
            nextState = ST_TURN;
            nextCnt   = CNT_W'(TURN_CYC - 1);
          end else begin
            nextState = ST_WRITE;
            nextCnt   = CNT_W'(WR_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (waitCnt == '0) begin
          nextState    = ST_WRITE;
          nextCnt      = CNT_W'(WR_CYC - 1);
          nextLastRead = 1'b0;
        end else begin
          nextCnt = waitCnt - 1'b1;
        end
      end
      ST_READ: begin
        if (waitCnt == '0) begin
          nextState    = ST_IDLE;
          nextLastRead = 1'b1;
        end else begin
          nextCnt = waitCnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (waitCnt == '0) begin
          nextState    = ST_IDLE;
          nextLastRead = 1'b0;
        end else begin
          nextCnt = waitCnt - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // strobes are registered from the next state: no decode glitches at the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWRUP;
      waitCnt  <= CNT_W'(PWR_CYC - 1);
      lastRead <= 1'b0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      dataOe   <= 1'b0;
    end else begin
      state    <= nextState;
      waitCnt  <= nextCnt;
      lastRead <= nextLastRead;
      memCeN   <= !(nextState == ST_READ || nextState == ST_WRITE);
      memWeN   <= (nextState != ST_WRITE);
      memOeN   <= (nextState != ST_READ);
      dataOe   <= (nextState == ST_WRITE);
    end
  end

  assign reqReady         = (state == ST_IDLE);
  assign strobe.loadReq   = (state == ST_IDLE) && reqValid;
  assign strobe.captureRd = (state == ST_READ) && (waitCnt == '0);

endmodule

// File: rtl/asram_ctrl_dpath.sv
module asram_ctrl_dpath
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr <= '0;
      memDout <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.captureRd;
      if (strobe.loadReq) begin
        memAddr <= reqAddr;
        memDout <= reqWdata;
      end
      if (strobe.captureRd) rdData <= memDin;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_PWE_NS      = 7,
  parameter int T_SD_NS       = 6,
  parameter int T_AW_NS       = 7,
  parameter int T_SCE_NS      = 8,
  parameter int T_HZOE_NS     = 5,
  parameter int T_PWRUP_NS    = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              dataOe,
  input  logic [DATA_W-1:0] memDin
);

  localparam int PWR_CYC  = nsToCycles(T_PWRUP_NS, CLK_PERIOD_NS);
  localparam int RD_CYC   = nsToCycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int WR_CYC   = nsToCycles(maxInt(maxInt(T_PWE_NS, T_SD_NS),
                                              maxInt(T_AW_NS, T_SCE_NS)), CLK_PERIOD_NS);
  localparam int TURN_CYC = nsToCycles(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC  = maxInt(maxInt(PWR_CYC, RD_CYC), maxInt(WR_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  dpStrobe_t strobe;

  asram_ctrl_fsm #(
    .PWR_CYC (PWR_CYC),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .dataOe  (dataOe)
  );

  asram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memDout (memDout),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_PWRUP_NS    = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [DATA_W-1:0] memDout,
  input logic              dataOe
);

  localparam int HOLD_CYC = nsToCycles(T_PWRUP_NS, CLK_PERIOD_NS);

  int holdCnt;
  always_ff @(posedge clk) begin
    if (rst) holdCnt <= 0;
    else if (holdCnt < HOLD_CYC) holdCnt <= holdCnt + 1;
  end

  AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (holdCnt < HOLD_CYC) |-> (memCeN && memWeN && memOeN && !reqReady));  // R1

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);  // R2

  AST_READ_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!memCeN && memWeN));  // R3

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDout)));  // R4

  AST_BUS_OWNER: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> (!memWeN && memOeN));  // R6

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(memOeN) |-> memWeN);  // R7

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);  // R8

  AST_STANDBY_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(memWeN) || $rose(memOeN)) |-> memCeN);  // R9

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_PWRUP_NS   (T_PWRUP_NS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDout (memDout),
  .dataOe  (dataOe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  // timing overrides and the cycle counts they imply at a 10 ns clock
  localparam int EXP_HOLD = 2000;  // 20000 ns
  localparam int EXP_RD   = 3;     // 25 ns
  localparam int EXP_WR   = 2;     // max(17,6,7,8) ns
  localparam int EXP_TURN = 2;     // 15 ns

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [3:0]  data;  // write data, or expected read data
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 18'h00001, 4'h5},  // write, from hold-off: no turn (R7)
    '{1'b1, 18'h3FFC2, 4'hA},  // write after write (R7), high address bits (R5)
    '{1'b0, 18'h00001, 4'h5},  // read back (R5)
    '{1'b0, 18'h3FFC2, 4'hA},  // read back (R5)
    '{1'b1, 18'h00001, 4'hF},  // write right after read: turnaround (R7)
    '{1'b1, 18'h20003, 4'h0},  // write after write
    '{1'b0, 18'h00001, 4'hF},  // overwritten value (R5)
    '{1'b0, 18'h20003, 4'h0},
    '{1'b0, 18'h00004, 4'hD}   // preloaded pattern 4^9 (R2)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0] reqWdata = '0;
  logic reqReady, rdValid, memCeN, memWeN, memOeN, dataOe;
  logic [3:0] rdData, memDout, memDin;
  logic [17:0] memAddr;

  int checks = 0;
  int fails = 0;
  int clashes = 0;

  always #5 clk = ~clk;

  asram_ctrl #(
    .T_AA_NS   (25),
    .T_PWE_NS  (17),
    .T_HZOE_NS (15),
    .T_PWRUP_NS(20000)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .dataOe(dataOe), .memDin(memDin)
  );

  // small memory model indexed by the low address bits
  logic [3:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 4'(i) ^ 4'h9;

  assign memDin = (!memCeN && !memOeN && memWeN) ? mem[memAddr[5:0]] : 4'h0;

  always @(negedge clk) begin
    if (!memCeN && !memWeN) mem[memAddr[5:0]] <= memDout;
    if ((dataOe && !memOeN) || (dataOe && memWeN) || (!memWeN && !dataOe)) clashes++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // release reset, then confirm ready rises after exactly EXP_HOLD edges
  task automatic runHoldOff(input string req);
    @(negedge clk);
    rst = 1'b0;
    repeat (EXP_HOLD - 1) begin
      @(negedge clk);
      if (!(memCeN && memWeN && memOeN && !reqReady))
        check(1'b0, req, "strobes during hold-off", {memCeN, memWeN, memOeN}, 7);
    end
    check(!reqReady, req, "ready one edge before hold-off end", int'(reqReady), 0);
    @(negedge clk);
    check(reqReady, req, "ready at hold-off end", int'(reqReady), 1);
  endtask

  task automatic doAccess(input vec_t v, input bit afterRead);
    int n;
    int lowCnt;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = v.wr; reqAddr = v.addr; reqWdata = v.data;
    n = 0;
    while (!reqReady && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);  // first cycle after acceptance
    reqValid = 1'b0;
    check(!reqReady, "R8", "ready after accept", int'(reqReady), 0);
    if (v.wr) begin
      n = 1;
      while (memWeN && n < 50) begin
        check(memCeN && memOeN && !dataOe, "R7", "strobes idle in gap",
              {memCeN, memOeN, dataOe}, 6);
        @(negedge clk); n++;
      end
      check(n == (afterRead ? EXP_TURN + 1 : 1), "R7", "cycle of write strobe fall",
            n, afterRead ? EXP_TURN + 1 : 1);
      lowCnt = 0;
      while (!memWeN && lowCnt < 50) begin
        check(!memCeN && memOeN && dataOe && memAddr == v.addr && memDout == v.data,
              "R4", "write window levels", int'(memAddr), int'(v.addr));
        lowCnt++;
        @(negedge clk);
      end
      check(lowCnt == EXP_WR, "R4", "write window length", lowCnt, EXP_WR);
      check(memCeN && memOeN && reqReady, "R9", "standby after write",
            {memCeN, memOeN, reqReady}, 7);
    end else begin
      n = 1;
      while (!rdValid && n < 50) begin
        check(!memCeN && !memOeN && memWeN && !reqReady && memAddr == v.addr,
              "R3", "read window levels", {memCeN, memOeN, memWeN}, 1);
        @(negedge clk); n++;
      end
      check(n == EXP_RD + 1, "R3", "read result cycle", n, EXP_RD + 1);
      check(rdData == v.data, "R2", "read data (R5 store)", int'(rdData), int'(v.data));
      check(memCeN && memOeN && reqReady, "R9", "standby after read",
            {memCeN, memOeN, reqReady}, 7);
      @(negedge clk);
      check(!rdValid, "R2", "valid lasts one cycle", int'(rdValid), 0);
    end
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    bit prevRead;
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memOeN, "R1", "strobes in reset", {memCeN, memWeN, memOeN}, 7);
    check(!reqReady && !rdValid && !dataOe, "R1", "ready/valid in reset",
          {reqReady, rdValid, dataOe}, 0);
    runHoldOff("R1");

    prevRead = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      doAccess(VECS[i], prevRead);
      prevRead = !VECS[i].wr;
    end

    // reset in the middle of a write window
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00007; reqWdata = 4'h3;
    for (int g = 0; g < 50 && memWeN; g++) @(negedge clk);
    reqValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(memCeN && memWeN && memOeN && !reqReady && !dataOe, "R10",
          "strobes after mid-write reset", {memCeN, memWeN, memOeN, reqReady}, 14);
    runHoldOff("R10");
    doAccess('{1'b0, 18'h00001, 4'hF}, 1'b0);  // R10: works again after hold-off

    check(clashes == 0, "R6", "bus drive conflicts", clashes, 0);
    finishRun();
  end

endmodule